// File: doc/BRIEF.md
# Bridge Legacy Display Forwarding Decoder

This block sits on the upstream side of a PCI-to-PCI bridge. For each request on the primary bus, it decides whether the bridge claims the request and passes it downstream to a legacy display adapter behind the bridge. The decision rests on three fixed legacy display ranges, not on the bridge's programmable base/limit windows. Two of the ranges are in I/O space and one is the legacy frame buffer in memory space.

The block holds two 16-bit registers, a command register and a bridge control register. Both are written through a simple configuration port with per-byte enables, and both can be read back. Forwarding is controlled by three enable bits:

- the display-forward enable in bridge control;
- the I/O space enable in the command register;
- the memory space enable in the command register.

The decode output is combinational from the registered enables. A separate one-hot output names the window that the current request falls in.

Top module: `vga_fwd_decoder`

## Requirements
- R1: After reset, the command register and the bridge control register both read as zero, and `fwd` stays low for every request.
- R2: An I/O request (`req_is_mem`=0) to a port from 0x3B0 to 0x3BB inclusive is claimed when I/O forwarding is active. Ports 0x3AF and 0x3BC are not claimed.
- R3: An I/O request to a port from 0x3C0 to 0x3DF inclusive is claimed when I/O forwarding is active. Ports 0x3BF and 0x3E0 are not claimed.
- R4: A memory request (`req_is_mem`=1) to an address from 0xA0000 to 0xBFFFF inclusive is claimed when memory forwarding is active. Addresses 0x9FFFF and 0xC0000 are not claimed.
- R5: I/O forwarding is active only when bridge control bit 3 (display-forward enable) and command bit 0 (I/O space enable) are both 1. The memory space enable has no effect on I/O requests.
- R6: Memory forwarding is active only when bridge control bit 3 and command bit 1 (memory space enable) are both 1. The I/O space enable has no effect on memory requests.
- R7: I/O decode compares only `req_addr[15:0]`, so any value in the upper bits still matches. Memory decode compares all 32 bits, so 0x100A0000 does not match.
- R8: Configuration write select 0 addresses the command register and select 1 addresses bridge control. Byte enable bit 0 covers data bits 7:0 and byte enable bit 1 covers bits 15:8. A write with a lane disabled leaves that lane unchanged. A write changes the decode from the next cycle on.
- R9: Unimplemented bits read back as zero. Only command bits 1:0 and bridge control bit 3 are implemented.
- R10: `win_hit` is one-hot: bit 0 is the low I/O window, bit 1 the high I/O window, and bit 2 the memory window. It reports the matching window whatever the enable bits are. When `req_valid` is 0, both `win_hit` and `fwd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears both registers |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 1 | Write target: 0 command, 1 bridge control |
| cfg_wr_be | input | 2 | Byte enables for the write |
| cfg_wr_data | input | 16 | Write data |
| cfg_rd_sel | input | 1 | Read target: 0 command, 1 bridge control |
| cfg_rd_data | output | 16 | Read-back value of the selected register |
| req_valid | input | 1 | A primary-bus request is present |
| req_is_mem | input | 1 | 1 for a memory request, 0 for an I/O request |
| req_addr | input | 32 | Request address |
| win_hit | output | 3 | One-hot matched window |
| fwd | output | 1 | Claim and forward the request downstream |

## Verification
Every I/O port from 0x380 to 0x3FF is swept under all eight combinations of the three enable bits. The sweep separates each window's inclusive edges from the ports just outside them, and shows which enable bit qualifies which request type.

Memory addresses on both sides of the frame-buffer edges are tried, including one that differs only in its upper bits, together with I/O addresses that carry set upper bits. These cases separate the 16-bit I/O compare from the 32-bit memory compare.

Writes with only one byte lane enabled, and writes of all ones, show lane masking and zero read-back of unimplemented bits.

// File: rtl/vga_fwd_pkg.sv
package vga_fwd_pkg;
    localparam int NUM_WIN      = 3;
    localparam int CMD_IO_BIT   = 0;
    localparam int CMD_MEM_BIT  = 1;
    localparam int BCTL_FWD_BIT = 3;

    typedef enum logic [0:0] {
        SEL_CMD  = 1'b0,
        SEL_BCTL = 1'b1
    } cfg_sel_e;

    // window 0: low I/O block, window 1: high I/O block, window 2: frame buffer
    function automatic logic [31:0] win_lo(input int idx);
        case (idx)
            0:       return 32'h0000_03B0;
            1:       return 32'h0000_03C0;
            default: return 32'h000A_0000;
        endcase
    endfunction

    function automatic logic [31:0] win_hi(input int idx);
        case (idx)
            0:       return 32'h0000_03BB;
            1:       return 32'h0000_03DF;
            default: return 32'h000B_FFFF;
        endcase
    endfunction

    function automatic bit win_is_mem(input int idx);
        return idx == 2;
    endfunction
endpackage

// File: rtl/vga_cfg_regs.sv
module vga_cfg_regs
    import vga_fwd_pkg::*;
#(
    parameter int REG_W = 16,
    localparam int LANES = REG_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [LANES-1:0] wr_be,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic             io_en,
    output logic             mem_en,
    output logic             fwd_en
);
    localparam logic [REG_W-1:0] CMD_IMPL  = (REG_W'(1) << CMD_IO_BIT) | (REG_W'(1) << CMD_MEM_BIT);
    localparam logic [REG_W-1:0] BCTL_IMPL = REG_W'(1) << BCTL_FWD_BIT;

    typedef struct packed {
        logic [REG_W-1:0] cmd;
        logic [REG_W-1:0] bctl;
    } cfg_state_t;

    cfg_state_t       state_d, state_q;
    logic [REG_W-1:0] lane_mask;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_mask[l*8 +: 8] = {8{wr_be[l]}};
    end

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            if (wr_sel == SEL_CMD)
                state_d.cmd  = ((state_q.cmd  & ~lane_mask) | (wr_data & lane_mask)) & CMD_IMPL;
            else
                state_d.bctl = ((state_q.bctl & ~lane_mask) | (wr_data & lane_mask)) & BCTL_IMPL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rd_data = (rd_sel == SEL_BCTL) ? state_q.bctl : state_q.cmd;
    assign io_en   = state_q.cmd[CMD_IO_BIT];
    assign mem_en  = state_q.cmd[CMD_MEM_BIT];
    assign fwd_en  = state_q.bctl[BCTL_FWD_BIT];

    AST_BCTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_BCTL && wr_be[0]) |=> fwd_en == $past(wr_data[BCTL_FWD_BIT])); // R8
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data) || $changed(rd_sel)); // R8
endmodule

// File: rtl/vga_win_cmp.sv
module vga_win_cmp #(
    parameter int              ADDR_W = 32,
    parameter int              CMP_W  = 16,
    parameter logic [ADDR_W-1:0] LO   = '0,
    parameter logic [ADDR_W-1:0] HI   = '0,
    parameter bit              IS_MEM = 1'b0
) (
    input  logic              valid,
    input  logic              is_mem,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [ADDR_W-1:0] cmp_addr;

    always_comb begin
        cmp_addr = '0;
        cmp_addr[CMP_W-1:0] = addr[CMP_W-1:0];
    end

    assign hit = valid && (is_mem == IS_MEM) && (cmp_addr >= LO) && (cmp_addr <= HI);
endmodule

// File: rtl/vga_fwd_decoder.sv
module vga_fwd_decoder
    import vga_fwd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IO_W   = 16,
    parameter int REG_W  = 16,
    localparam int LANES = REG_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic               cfg_wr_sel,
    input  logic [LANES-1:0]   cfg_wr_be,
    input  logic [REG_W-1:0]   cfg_wr_data,
    input  logic               cfg_rd_sel,
    output logic [REG_W-1:0]   cfg_rd_data,
    input  logic               req_valid,
    input  logic               req_is_mem,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic [NUM_WIN-1:0] win_hit,
    output logic               fwd
);
    logic               io_en, mem_en, fwd_en;
    logic               io_ok, mem_ok;
    logic [NUM_WIN-1:0] allow;

    vga_cfg_regs #(.REG_W(REG_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .wr_be   (cfg_wr_be),
        .wr_data (cfg_wr_data),
        .rd_sel  (cfg_rd_sel),
        .rd_data (cfg_rd_data),
        .io_en   (io_en),
        .mem_en  (mem_en),
        .fwd_en  (fwd_en)
    );

    assign io_ok  = fwd_en && io_en;
    assign mem_ok = fwd_en && mem_en;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        vga_win_cmp #(
            .ADDR_W (ADDR_W),
            .CMP_W  (win_is_mem(w) ? ADDR_W : IO_W),
            .LO     (ADDR_W'(win_lo(w))),
            .HI     (ADDR_W'(win_hi(w))),
            .IS_MEM (win_is_mem(w))
        ) cmp_i (
            .valid  (req_valid),
            .is_mem (req_is_mem),
            .addr   (req_addr),
            .hit    (win_hit[w])
        );
        assign allow[w] = win_is_mem(w) ? mem_ok : io_ok;
    end

    assign fwd = |(win_hit & allow);

    AST_FWD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        fwd |-> fwd_en && (req_is_mem ? mem_en : io_en)); // R5
    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_hit)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (win_hit == '0) && !fwd); // R10
    AST_MEM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd && req_is_mem) |-> (req_addr >= ADDR_W'(32'hA0000)) && (req_addr <= ADDR_W'(32'hBFFFF))); // R4
endmodule

// File: tb/vga_fwd_decoder_tb_top.sv
`timescale 1ns/1ps
module vga_fwd_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_wr_sel = 1'b0;
    logic [1:0]  cfg_wr_be = 2'b00;
    logic [15:0] cfg_wr_data = '0;
    logic        cfg_rd_sel = 1'b0;
    logic [15:0] cfg_rd_data;
    logic        req_valid = 1'b0;
    logic        req_is_mem = 1'b0;
    logic [31:0] req_addr = '0;
    logic [2:0]  win_hit;
    logic        fwd;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vga_fwd_decoder dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_be(cfg_wr_be),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
        .req_valid(req_valid), .req_is_mem(req_is_mem), .req_addr(req_addr),
        .win_hit(win_hit), .fwd(fwd)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h (addr=%0h mem=%0b)", req, got, exp, req_addr, req_is_mem);
        end
    endtask

    function automatic logic [2:0] exp_hit(input logic is_mem, input logic [31:0] a);
        logic [2:0] h = 3'b000;
        if (!is_mem) begin
            if (a[15:0] >= 16'h3B0 && a[15:0] <= 16'h3BB) h[0] = 1'b1;
            if (a[15:0] >= 16'h3C0 && a[15:0] <= 16'h3DF) h[1] = 1'b1;
        end else if (a >= 32'hA0000 && a <= 32'hBFFFF) h[2] = 1'b1;
        return h;
    endfunction

    task automatic cfg_write(input logic sel, input logic [15:0] data, input logic [1:0] be);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data; cfg_wr_be = be;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_wr_be = 2'b00;
        #1;
    endtask

    task automatic probe(input logic is_mem, input logic [31:0] a, input logic f, input logic i, input logic m,
                         input string req);
        logic [2:0] h;
        logic       ef;
        req_valid = 1'b1; req_is_mem = is_mem; req_addr = a;
        #1;
        h  = exp_hit(is_mem, a);
        ef = (|h[1:0] && f && i) || (h[2] && f && m);
        check({req, "/R10 hit"}, 32'(win_hit), 32'(h));
        check({req, " fwd"}, 32'(fwd), 32'(ef));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        cfg_rd_sel = 1'b0; #1 check("R1 cmd rdback", 32'(cfg_rd_data), 0);
        cfg_rd_sel = 1'b1; #1 check("R1 bctl rdback", 32'(cfg_rd_data), 0);
        req_valid = 1'b1; req_is_mem = 1'b1; req_addr = 32'hA0000; #1
        check("R1 fwd in reset", 32'(fwd), 0);
        @(negedge clk); rst_n = 1'b1; #1
        check("R1 fwd after reset", 32'(fwd), 0);

        // R9 / R8: lane masking and unimplemented bits
        cfg_write(1'b1, 16'h0008, 2'b10);
        cfg_rd_sel = 1'b1; #1 check("R8 lane1-only write leaves bctl", 32'(cfg_rd_data), 0);
        cfg_write(1'b1, 16'hFFFF, 2'b11);
        #1 check("R9 bctl readback", 32'(cfg_rd_data), 32'h0008);
        cfg_write(1'b0, 16'hFFFF, 2'b11);
        cfg_rd_sel = 1'b0; #1 check("R9 cmd readback", 32'(cfg_rd_data), 32'h0003);
        cfg_write(1'b0, 16'h0000, 2'b10);
        #1 check("R8 lane1 write keeps cmd", 32'(cfg_rd_data), 32'h0003);
        cfg_write(1'b0, 16'hFF00, 2'b01);
        #1 check("R8 lane0 write clears cmd", 32'(cfg_rd_data), 0);

        // R10: idle request
        req_valid = 1'b0; req_is_mem = 1'b0; req_addr = 32'h3C0; #1
        check("R10 idle hit", 32'(win_hit), 0);
        check("R10 idle fwd", 32'(fwd), 0);

        // sweep all enable combinations
        for (int c = 0; c < 8; c++) begin
            logic f, i, m;
            f = c[2]; i = c[0]; m = c[1];
            cfg_write(1'b0, {14'd0, m, i}, 2'b11);
            cfg_write(1'b1, {12'd0, f, 3'd0}, 2'b11);
            for (int p = 16'h380; p < 16'h400; p++)
                probe(1'b0, 32'(p), f, i, m, "R2/R3/R5 io sweep");
            probe(1'b0, 32'hABCD_03B5, f, i, m, "R7 io upper bits");
            probe(1'b0, 32'h0001_03DF, f, i, m, "R7 io upper bits");
            probe(1'b0, 32'h000A_0000, f, i, m, "R6 io at fb addr");
            probe(1'b1, 32'h0009_FFFF, f, i, m, "R4 mem below");
            probe(1'b1, 32'h000A_0000, f, i, m, "R4/R6 mem low edge");
            probe(1'b1, 32'h000A_FFFF, f, i, m, "R4/R6 mem mid");
            probe(1'b1, 32'h000B_FFFF, f, i, m, "R4/R6 mem high edge");
            probe(1'b1, 32'h000C_0000, f, i, m, "R4 mem above");
            probe(1'b1, 32'h100A_0000, f, i, m, "R7 mem upper bits");
            probe(1'b1, 32'h0000_03C4, f, i, m, "R5 mem at io addr");
        end
        req_valid = 1'b0;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule